// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Lane Unit

This unit performs lane-parallel saturating integer arithmetic for a 128-bit SIMD datapath. One strobe presents two source vectors, the old value of the destination register, an element size code and a handful of mode bits. The unit returns the new destination value one clock later. Each lane's result is clamped to the representable range of its element type instead of wrapping.

Three operations are available. The first is a plain add. The second is a plain subtract, taking the first source minus the second. The third is an accumulate: the first source is read with the signedness opposite to the destination, added into the old destination value, and clamped to the destination's type.

Any active lane that clamps sets a sticky saturation bit in a 32-bit status word. Only reset clears it. Scalar mode computes lane 0 alone. A half-width register mode uses only the low 64 bits. Every byte outside the active lanes is returned as zero.

Top module: `simd_satq_unit`

## Requirements
- R1: The size code sets the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32, 3 gives 64. In full-width vector mode all 128/width lanes are computed independently.
- R2: With signed mode set and no subtract or accumulate, each lane returns the signed sum. The sum is clamped to the signed maximum or the signed minimum when it falls outside that range.
- R3: With signed mode clear, the add returns the unsigned sum clamped to all-ones. The subtract (sub_i=1) returns a minus b, clamped to zero when it would go negative.
- R4: With signed mode set and sub_i=1, each lane returns the signed difference a minus b, clamped to the signed range.
- R5: With accum_i=1 and signed mode set, each lane returns old destination (signed) plus source a read as unsigned, clamped to the signed range. sub_i has no effect while accum_i=1.
- R6: With accum_i=1 and signed mode clear, each lane returns old destination (unsigned) plus source a read as signed, clamped to the range 0 to all-ones.
- R7: In scalar mode only lane 0 is computed, and all result bits above that element are zero.
- R8: In vector mode with wide_i=0, only the lanes in the low 64 bits are computed, and result bits 127:64 are zero.
- R9: Status bit 27 is set whenever an active lane clamps. Lanes outside the active set never set it. Once set, it stays set until reset.
- R10: Result, status and res_valid_o update on the clock edge that samples valid_i=1. Without valid_i the result and status hold, and res_valid_o is low.
- R11: After reset, result, status and res_valid_o are all zero.
- R12: Every status bit other than bit 27 is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Element size code |
| scalar_i | input | 1 | Compute lane 0 only |
| wide_i | input | 1 | 1: 128-bit register, 0: low 64 bits only |
| signed_i | input | 1 | Destination / operand signedness |
| sub_i | input | 1 | Subtract instead of add |
| accum_i | input | 1 | Accumulate a into the old destination |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| dst_old_i | input | 128 | Old destination value |
| result_o | output | 128 | Registered result |
| res_valid_o | output | 1 | High the cycle after a strobe |
| status_o | output | 32 | Status word with sticky saturation bit 27 |

## Verification
Every result, the saturation bit and res_valid_o are due exactly one rising edge after the edge that samples valid_i. The bench drives inputs on a falling edge and holds the strobe for one period. It compares all outputs at the next falling edge, halfway between that capture edge and the next one. A further idle falling edge then checks that nothing moved without a strobe. The expected sticky flag is accumulated in the bench, so a flag that clears or misses a clamp shows up on a later comparison.

// File: rtl/satq_pkg.sv
package satq_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_ACC = 2'd2
   } satq_op_e;

   localparam int SIZE_CODES = 4;

   function automatic int elem_bits(input int code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/satq_lane.sv
module satq_lane
   import satq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] d,
   input  logic         is_signed,
   input  satq_op_e     op,
   output logic [W-1:0] res,
   output logic         sat
);

   logic [W-1:0] rhs;
   logic         a_sgn;

   always_comb begin
      rhs   = (op == OP_ACC) ? d : b;
      a_sgn = (op == OP_ACC) ? ~is_signed : is_signed;
   end

   if (W < 64) begin : g_widen
      localparam int X = W + 2;
      logic signed [X-1:0] xa, xb, sum, maxv, minv;

      always_comb begin
         xa   = a_sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
         xb   = is_signed ? {{2{rhs[W-1]}}, rhs} : {2'b00, rhs};
         sum  = (op == OP_SUB) ? (xa - xb) : (xa + xb);
         maxv = is_signed ? {3'b000, {(W-1){1'b1}}} : {2'b00, {W{1'b1}}};
         minv = is_signed ? {3'b111, {(W-1){1'b0}}} : '0;
         if (sum > maxv) begin
            res = maxv[W-1:0];
            sat = 1'b1;
         end else if (sum < minv) begin
            res = minv[W-1:0];
            sat = 1'b1;
         end else begin
            res = sum[W-1:0];
            sat = 1'b0;
         end
      end
   end else begin : g_flag
      logic [W:0]   raw;
      logic         cy;
      logic [W-1:0] s;
      logic         am, rm, sm;
      logic [W-1:0] smax, smin, umax;

      always_comb begin
         raw  = (op == OP_SUB) ? ({1'b0, a} - {1'b0, rhs}) : ({1'b0, a} + {1'b0, rhs});
         cy   = raw[W];
         s    = raw[W-1:0];
         am   = a[W-1];
         rm   = rhs[W-1];
         sm   = s[W-1];
         smax = {1'b0, {(W-1){1'b1}}};
         smin = {1'b1, {(W-1){1'b0}}};
         umax = '1;
         res  = s;
         sat  = 1'b0;
         unique case (op)
            OP_ADD: begin
               if (is_signed) begin
                  if ((am == rm) && (sm != am)) begin
                     sat = 1'b1;
                     res = am ? smin : smax;
                  end
               end else if (cy) begin
                  sat = 1'b1;
                  res = umax;
               end
            end
            OP_SUB: begin
               if (is_signed) begin
                  if ((am != rm) && (sm != am)) begin
                     sat = 1'b1;
                     res = am ? smin : smax;
                  end
               end else if (cy) begin
                  sat = 1'b1;
                  res = '0;
               end
            end
            OP_ACC: begin
               if (is_signed) begin
                  // a unsigned, d signed: only upward overflow is possible
                  if ((am & ~rm) | (~am & ~rm & sm) | (am & rm & sm)) begin
                     sat = 1'b1;
                     res = smax;
                  end
               end else begin
                  // a signed, d unsigned
                  if (~am & cy) begin
                     sat = 1'b1;
                     res = umax;
                  end else if (am & ~cy) begin
                     sat = 1'b1;
                     res = '0;
                  end
               end
            end
            default: begin
               res = s;
               sat = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/satq_bank.sv
module satq_bank
   import satq_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int W      = 8
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  logic [DATA_W-1:0]   d,
   input  logic                is_signed,
   input  satq_op_e            op,
   output logic [DATA_W-1:0]   res,
   output logic [DATA_W/8-1:0] sat
);

   localparam int N    = DATA_W / W;
   localparam int MAXL = DATA_W / 8;

   for (genvar k = 0; k < MAXL; k++) begin : g_slot
      if (k < N) begin : g_lane
         satq_lane #(.W(W)) u_lane (
            .a         (a[k*W +: W]),
            .b         (b[k*W +: W]),
            .d         (d[k*W +: W]),
            .is_signed (is_signed),
            .op        (op),
            .res       (res[k*W +: W]),
            .sat       (sat[k])
         );
      end else begin : g_pad
         assign sat[k] = 1'b0;
      end
   end

endmodule

// File: rtl/simd_satq_unit.sv
module simd_satq_unit
   import satq_pkg::*;
#(
   parameter int DATA_W   = 128,
   parameter int HALF_W   = 64,
   parameter int STATUS_W = 32,
   parameter int SAT_BIT  = 27
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   input  logic [1:0]          size_i,
   input  logic                scalar_i,
   input  logic                wide_i,
   input  logic                signed_i,
   input  logic                sub_i,
   input  logic                accum_i,
   input  logic [DATA_W-1:0]   src_a_i,
   input  logic [DATA_W-1:0]   src_b_i,
   input  logic [DATA_W-1:0]   dst_old_i,
   output logic [DATA_W-1:0]   result_o,
   output logic                res_valid_o,
   output logic [STATUS_W-1:0] status_o
);

   localparam int NBYTES = DATA_W / 8;
   localparam int CNT_W  = $clog2(NBYTES) + 1;

   if (DATA_W % 64 != 0) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 64");
   end
   if (HALF_W > DATA_W || HALF_W % 64 != 0) begin : g_bad_half_w
      $error("HALF_W must be a multiple of 64 no larger than DATA_W");
   end
   if (SAT_BIT >= STATUS_W) begin : g_bad_sat_bit
      $error("SAT_BIT must lie inside the status word");
   end

   satq_op_e          op;
   logic [DATA_W-1:0] res_all [SIZE_CODES];
   logic [NBYTES-1:0] sat_all [SIZE_CODES];

   always_comb begin
      if (accum_i)    op = OP_ACC;
      else if (sub_i) op = OP_SUB;
      else            op = OP_ADD;
   end

   for (genvar g = 0; g < SIZE_CODES; g++) begin : g_size
      satq_bank #(.DATA_W(DATA_W), .W(elem_bits(g))) u_bank (
         .a         (src_a_i),
         .b         (src_b_i),
         .d         (dst_old_i),
         .is_signed (signed_i),
         .op        (op),
         .res       (res_all[g]),
         .sat       (sat_all[g])
      );
   end

   logic [CNT_W-1:0]  full_cnt, lane_cnt, lane_of;
   logic [NBYTES-1:0] byte_act, lane_act, sat_sel;
   logic [DATA_W-1:0] res_sel, res_msk;
   logic              sat_any;

   always_comb begin
      full_cnt = wide_i ? CNT_W'(NBYTES) : CNT_W'(HALF_W / 8);
      lane_cnt = scalar_i ? CNT_W'(1) : (full_cnt >> size_i);
      res_sel  = res_all[size_i];
      sat_sel  = sat_all[size_i];
      for (int j = 0; j < NBYTES; j++) begin
         lane_of     = CNT_W'(j) >> size_i;
         byte_act[j] = lane_of < lane_cnt;
         lane_act[j] = CNT_W'(j) < lane_cnt;
         res_msk[j*8 +: 8] = byte_act[j] ? res_sel[j*8 +: 8] : 8'h00;
      end
      sat_any = |(sat_sel & lane_act);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o    <= '0;
         res_valid_o <= 1'b0;
         status_o    <= '0;
      end else begin
         res_valid_o <= valid_i;
         if (valid_i) begin
            result_o          <= res_msk;
            status_o[SAT_BIT] <= status_o[SAT_BIT] | sat_any;
         end
      end
   end

endmodule

// File: rtl/satq_chk.sv
module satq_chk #(
   parameter int DATA_W   = 128,
   parameter int HALF_W   = 64,
   parameter int STATUS_W = 32,
   parameter int SAT_BIT  = 27
) (
   input logic                clk,
   input logic                rst_n,
   input logic                valid_i,
   input logic [1:0]          size_i,
   input logic                scalar_i,
   input logic                wide_i,
   input logic [DATA_W-1:0]   result_o,
   input logic                res_valid_o,
   input logic [STATUS_W-1:0] status_o
);

   localparam logic [STATUS_W-1:0] OTHER_BITS = ~(STATUS_W'(1) << SAT_BIT);

   // R9
   sticky_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[SAT_BIT] |=> status_o[SAT_BIT]);

   // R12
   other_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & OTHER_BITS) == '0);

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> res_valid_o);

   // R10
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !res_valid_o);

   // R10
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(result_o) && $stable(status_o)));

   // R7
   scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && scalar_i) |=> ((result_o >> (8 << $past(size_i))) == '0));

   // R8
   half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !scalar_i && !wide_i) |=> ((result_o >> HALF_W) == '0));

endmodule

bind simd_satq_unit satq_chk #(
   .DATA_W(DATA_W), .HALF_W(HALF_W), .STATUS_W(STATUS_W), .SAT_BIT(SAT_BIT)
) u_satq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .valid_i     (valid_i),
   .size_i      (size_i),
   .scalar_i    (scalar_i),
   .wide_i      (wide_i),
   .result_o    (result_o),
   .res_valid_o (res_valid_o),
   .status_o    (status_o)
);

// File: tb/sim_simd_satq_unit.sv
module sim_simd_satq_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_i = 1'b0;
   logic [1:0]   size_i = '0;
   logic         scalar_i = 1'b0, wide_i = 1'b1, signed_i = 1'b0, sub_i = 1'b0, accum_i = 1'b0;
   logic [127:0] src_a_i = '0, src_b_i = '0, dst_old_i = '0;
   logic [127:0] result_o;
   logic         res_valid_o;
   logic [31:0]  status_o;

   int  checks = 0;
   int  failures = 0;
   bit  done = 0;
   bit  exp_qc = 0;

   always #10 clk = ~clk;

   simd_satq_unit u0 (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .size_i(size_i),
      .scalar_i(scalar_i), .wide_i(wide_i), .signed_i(signed_i), .sub_i(sub_i),
      .accum_i(accum_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_old_i(dst_old_i),
      .result_o(result_o), .res_valid_o(res_valid_o), .status_o(status_o)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lmask(input int w);
      return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
   endfunction

   // reference: widen to 72 bits signed, clamp, pack
   function automatic logic [128:0] model(input logic [1:0] sz, input bit sc, wd, sg, sb, ac,
                                          input logic [127:0] a, b, d);
      int w = 8 << sz;
      int n = sc ? 1 : ((wd ? 16 : 8) >> sz);
      logic [127:0] r = '0;
      bit s = 0;
      for (int k = 0; k < n; k++) begin
         logic [63:0] ea, eo;
         logic signed [71:0] va, vb, vr, mx, mn;
         bit sa;
         ea = 64'(a >> (k * w)) & lmask(w);
         eo = 64'((ac ? d : b) >> (k * w)) & lmask(w);
         sa = ac ? !sg : sg;
         va = {8'd0, ea};
         if (sa && ea[w-1]) va = va - (72'sd1 <<< w);
         vb = {8'd0, eo};
         if (sg && eo[w-1]) vb = vb - (72'sd1 <<< w);
         vr = (sb && !ac) ? (va - vb) : (va + vb);
         mx = sg ? ((72'sd1 <<< (w - 1)) - 72'sd1) : ((72'sd1 <<< w) - 72'sd1);
         mn = sg ? -(72'sd1 <<< (w - 1)) : 72'sd0;
         if (vr > mx) begin vr = mx; s = 1; end
         else if (vr < mn) begin vr = mn; s = 1; end
         r = r | (128'(vr[63:0] & lmask(w)) << (k * w));
      end
      return {s, r};
   endfunction

   function automatic logic [127:0] rep(input logic [1:0] sz, input logic [63:0] v);
      int w = 8 << sz;
      logic [127:0] r = '0;
      for (int k = 0; k < (16 >> sz); k++) r = r | (128'(v & lmask(w)) << (k * w));
      return r;
   endfunction

   function automatic string tag_of(input bit sc, wd, sg, sb, ac);
      if (sc) return "R7";
      if (!wd) return "R8";
      if (ac) return sg ? "R5" : "R6";
      if (sb) return sg ? "R4" : "R3";
      return sg ? "R2" : "R3";
   endfunction

   task automatic run_op(input logic [1:0] sz, input bit sc, wd, sg, sb, ac,
                         input logic [127:0] a, b, d, input string tag);
      logic [128:0] m;
      m = model(sz, sc, wd, sg, sb, ac, a, b, d);
      exp_qc = exp_qc | m[128];
      @(negedge clk);
      size_i = sz; scalar_i = sc; wide_i = wd; signed_i = sg; sub_i = sb; accum_i = ac;
      src_a_i = a; src_b_i = b; dst_old_i = d; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check({tag, " R1 result"}, result_o, m[127:0]);
      check("R9 status", 128'(status_o), 128'({4'b0, exp_qc, 27'b0}));
      check("R12 other status bits", 128'(status_o & 32'hF7FF_FFFF), 128'd0);
      check("R10 res_valid high", 128'(res_valid_o), 128'd1);
   endtask

   task automatic idle_hold;
      logic [127:0] prev;
      logic [31:0]  pst;
      prev = result_o;
      pst = status_o;
      src_a_i = {$urandom, $urandom, $urandom, $urandom};
      src_b_i = ~src_a_i;
      @(negedge clk);
      check("R10 result held", result_o, prev);
      check("R10 status held", 128'(status_o), 128'(pst));
      check("R10 res_valid low", 128'(res_valid_o), 128'd0);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      valid_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_qc = 0;
      check("R11 reset result", result_o, 128'd0);
      check("R11 reset status", 128'(status_o), 128'd0);
      check("R11 reset res_valid", 128'(res_valid_o), 128'd0);
   endtask

   function automatic logic [63:0] pick(input logic [1:0] sz);
      int w = 8 << sz;
      logic [63:0] smax, smin;
      smax = lmask(w) >> 1;
      smin = smax + 64'd1;
      case ($urandom % 6)
         0: return smax;
         1: return smin & lmask(w);
         2: return lmask(w);
         3: return 64'd0;
         4: return 64'd1;
         default: return {$urandom, $urandom} & lmask(w);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd2024));
      do_reset();

      // directed corners at every element size
      for (int z = 0; z < 4; z++) begin
         logic [1:0] sz;
         logic [63:0] smax, smin, um, one;
         sz = 2'(z);
         um = lmask(8 << z);
         smax = um >> 1;
         smin = smax + 64'd1;
         one = 64'd1;
         run_op(sz, 0, 1, 1, 0, 0, rep(sz, smax), rep(sz, one), '0, "R2");
         run_op(sz, 0, 1, 1, 0, 0, rep(sz, smin), rep(sz, um), '0, "R2");
         run_op(sz, 0, 1, 1, 0, 0, rep(sz, one), rep(sz, one), '0, "R2");
         run_op(sz, 0, 1, 0, 0, 0, rep(sz, um), rep(sz, one), '0, "R3");
         run_op(sz, 0, 1, 0, 1, 0, rep(sz, 0), rep(sz, one), '0, "R3");
         run_op(sz, 0, 1, 1, 1, 0, rep(sz, smin), rep(sz, one), '0, "R4");
         run_op(sz, 0, 1, 1, 1, 0, rep(sz, smax), rep(sz, um), '0, "R4");
         run_op(sz, 0, 1, 1, 0, 1, rep(sz, um), '0, rep(sz, one), "R5");
         run_op(sz, 0, 1, 1, 0, 1, rep(sz, one), '0, rep(sz, smin), "R5");
         run_op(sz, 0, 1, 1, 1, 1, rep(sz, smin), rep(sz, one), rep(sz, smin), "R5 sub ignored");
         run_op(sz, 0, 1, 0, 0, 1, rep(sz, um), '0, rep(sz, 0), "R6");
         run_op(sz, 0, 1, 0, 0, 1, rep(sz, smax), '0, rep(sz, um), "R6");
         run_op(sz, 0, 1, 0, 0, 1, rep(sz, um), '0, rep(sz, one), "R6");
         idle_hold();
      end

      // inactive lanes must not raise the flag
      do_reset();
      run_op(2'd0, 1, 1, 1, 0, 0, {{15{8'h7F}}, 8'h01}, {{15{8'h01}}, 8'h01}, '0, "R7 R9");
      run_op(2'd1, 0, 0, 1, 0, 0, {{4{16'h7FFF}}, {4{16'h0001}}}, {{4{16'h0001}}, {4{16'h0002}}}, '0, "R8 R9");
      run_op(2'd3, 0, 0, 0, 1, 0, {64'd0, 64'd5}, {64'd1, 64'd3}, '0, "R8 R9");
      run_op(2'd3, 1, 1, 0, 0, 0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd0, 64'd1}, '0, "R7 R9");
      run_op(2'd2, 0, 1, 0, 0, 0, rep(2'd2, 64'd1), rep(2'd2, 64'd1), '0, "R9 sticky");
      idle_hold();

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [1:0] sz;
         bit sc, wd, sg, sb, ac;
         logic [127:0] a, b, d;
         sz = 2'($urandom % 4);
         sc = ($urandom % 5) == 0;
         wd = ($urandom % 4) != 0;
         sg = $urandom % 2;
         sb = $urandom % 2;
         ac = ($urandom % 3) == 0;
         a = '0; b = '0; d = '0;
         for (int k = 0; k < (16 >> sz); k++) begin
            a = a | (128'(pick(sz)) << (k * (8 << sz)));
            b = b | (128'(pick(sz)) << (k * (8 << sz)));
            d = d | (128'(pick(sz)) << (k * (8 << sz)));
         end
         run_op(sz, sc, wd, sg, sb, ac, a, b, d, tag_of(sc, wd, sg, sb, ac));
         if (i % 50 == 0) idle_hold();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule